// File: doc/BRIEF.md
# Cartridge Bank-Switching Address Mapper

This block sits between a 6502-style CPU bus, a picture-processor pattern bus and the cartridge ROMs. CPU writes anywhere in the upper 32 KiB land in a small register file, and the low four address bits pick the register. From those registers the block builds ROM addresses with plain combinational logic.

On the program side, CPU space 0x8000–0xBFFF shows one switchable 16 KiB bank of a program ROM of up to 256 KiB. CPU space 0xC000–0xFFFF always shows the last bank. On the pattern side, the 8 KiB pattern space is split into eight 1 KiB windows. Each window points at its own 1 KiB bank of a character space of up to 128 KiB.

The block also drives a nametable mirroring select. Bank numbers are reduced modulo the number of banks actually fitted, which is set by parameters. The timer, the serial save memory and any save-data area lie outside this block.

Top module: `cart_bank_mapper`

## Requirements
- R1: A register write happens only when `cpu_wr` is high at a rising `clk` edge and `cpu_addr[15]` is 1. `cpu_addr[3:0]` selects the register, whatever bits 14..4 hold. A write with `cpu_addr[15]`=0 changes nothing.
- R2: Pattern window n is `ppu_addr[12:10]`. `chr_rom_addr` equals {character bank register n, `ppu_addr[9:0]`}. Register n (n = 0..7) is written at offset n from `cpu_data[6:0]`.
- R3: For `cpu_addr` 0x8000–0xBFFF, `prg_rom_addr` equals {program bank register, `cpu_addr[13:0]`}. The program bank register is written at offset 8 from `cpu_data[3:0]`.
- R4: For `cpu_addr` 0xC000–0xFFFF, `prg_rom_addr` equals {PRG_BANKS-1, `cpu_addr[13:0]`}, whatever the program bank register holds.
- R5: A write to offset 9 sets `mirror_horiz` to `cpu_data[0]`: 0 is vertical and 1 is horizontal.
- R6: `prg_rom_sel` is 1 exactly when `cpu_addr[15]` is 1. It is 0 for 0x6000–0x7FFF, which the block leaves undriven.
- R7: Writes to offsets 0xA–0xF, including the save-memory data port at 0xD, change no bank register and not `mirror_horiz`.
- R8: A bank number is reduced modulo PRG_BANKS (program) or CHR_BANKS (character) before it reaches the ROM address.
- R9: After reset, the program bank register, all eight character bank registers and `mirror_horiz` are 0.
- R10: A write takes effect at the clock edge that samples it. Before that edge the outputs still reflect the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU bus clock; writes are sampled on its rising edge |
| rst_n | input | 1 | Active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, active high |
| ppu_addr | input | 13 | Pattern-bus address |
| prg_rom_sel | output | 1 | Program ROM select for the upper 32 KiB |
| prg_rom_addr | output | 18 | Program ROM byte address |
| chr_rom_addr | output | 17 | Character memory byte address |
| mirror_horiz | output | 1 | Nametable mirroring: 0 vertical, 1 horizontal |

## Verification
A distinct bank number is written into each of the eight character windows. Each window is then read at its first and last byte, which separates a window-index decode error from an offset-bit error.

The program window is driven with in-range and oversize bank numbers. This tells correct wrapping apart from truncation, and the fixed upper bank is read back after each change to show it never follows the register.

Writes are repeated at mirrored addresses such as 0xFFF8 and at 0x0008. This separates a nibble-only decode from a decode that forgets bit 15.

Writes to the unused offsets, and a sample taken in the very cycle of a write, show that nothing leaks from ignored offsets and that the update lands on the sampling edge.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  localparam int PRG_BANK_W  = 4;
  localparam int CHR_BANK_W  = 7;
  localparam int PRG_OFS_W   = 14;
  localparam int CHR_OFS_W   = 10;
  localparam int CHR_WINDOWS = 8;
  localparam int WIN_IDX_W   = $clog2(CHR_WINDOWS);
  localparam int PRG_AW      = PRG_BANK_W + PRG_OFS_W;
  localparam int CHR_AW      = CHR_BANK_W + CHR_OFS_W;
  localparam logic [3:0] OFS_PRG    = 4'h8;
  localparam logic [3:0] OFS_MIRROR = 4'h9;

  function automatic logic [PRG_BANK_W-1:0] wrap_prg(input logic [PRG_BANK_W-1:0] b,
                                                     input int unsigned n);
    return PRG_BANK_W'(32'(b) % n);
  endfunction

  function automatic logic [CHR_BANK_W-1:0] wrap_chr(input logic [CHR_BANK_W-1:0] b,
                                                     input int unsigned n);
    return CHR_BANK_W'(32'(b) % n);
  endfunction
endpackage

// File: rtl/cbm_reg_file.sv
module cbm_reg_file
  import cbm_pkg::*;
(
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic [15:0]                              cpu_addr,
  input  logic [7:0]                               cpu_data,
  input  logic                                     cpu_wr,
  output logic [15:0]                              wr_sel,
  output logic [PRG_BANK_W-1:0]                    prg_bank,
  output logic [CHR_WINDOWS-1:0][CHR_BANK_W-1:0]   chr_bank,
  output logic                                     mirror_horiz
);
  logic wr_hit;
  logic unused_bits;

  assign unused_bits = ^{cpu_data[7], cpu_addr[14:4]};
  assign wr_hit      = cpu_wr && cpu_addr[15];

  always_comb begin
    wr_sel = '0;
    if (wr_hit) wr_sel[cpu_addr[3:0]] = 1'b1;
  end

  for (genvar w = 0; w < CHR_WINDOWS; w++) begin : g_chr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        chr_bank[w] <= '0;
      else if (wr_sel[w]) chr_bank[w] <= cpu_data[CHR_BANK_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prg_bank     <= '0;
      mirror_horiz <= 1'b0;
    end else begin
      if (wr_sel[OFS_PRG])    prg_bank     <= cpu_data[PRG_BANK_W-1:0];
      if (wr_sel[OFS_MIRROR]) mirror_horiz <= cpu_data[0];
    end
  end
endmodule

// File: rtl/cbm_prg_xlate.sv
module cbm_prg_xlate
  import cbm_pkg::*;
#(
  parameter int unsigned PRG_BANKS = 16
) (
  input  logic [15:0]           cpu_addr,
  input  logic [PRG_BANK_W-1:0] prg_bank,
  output logic                  prg_rom_sel,
  output logic [PRG_AW-1:0]     prg_rom_addr
);
  localparam logic [PRG_BANK_W-1:0] LAST_BANK = PRG_BANK_W'(PRG_BANKS - 1);

  logic                  upper_fixed;
  logic [PRG_BANK_W-1:0] bank_eff;

  assign upper_fixed  = cpu_addr[14];
  assign bank_eff     = upper_fixed ? LAST_BANK : wrap_prg(prg_bank, PRG_BANKS);
  assign prg_rom_addr = {bank_eff, cpu_addr[PRG_OFS_W-1:0]};
  assign prg_rom_sel  = cpu_addr[15];
endmodule

// File: rtl/cbm_chr_xlate.sv
module cbm_chr_xlate
  import cbm_pkg::*;
#(
  parameter int unsigned CHR_BANKS = 128
) (
  input  logic [12:0]                              ppu_addr,
  input  logic [CHR_WINDOWS-1:0][CHR_BANK_W-1:0]   chr_bank,
  output logic [CHR_AW-1:0]                        chr_rom_addr
);
  logic [WIN_IDX_W-1:0]  win_idx;
  logic [CHR_BANK_W-1:0] bank_eff;

  assign win_idx      = ppu_addr[CHR_OFS_W +: WIN_IDX_W];
  assign bank_eff     = wrap_chr(chr_bank[win_idx], CHR_BANKS);
  assign chr_rom_addr = {bank_eff, ppu_addr[CHR_OFS_W-1:0]};
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cbm_pkg::*;
#(
  parameter int unsigned PRG_BANKS = 16,
  parameter int unsigned CHR_BANKS = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_data,
  input  logic              cpu_wr,
  input  logic [12:0]       ppu_addr,
  output logic              prg_rom_sel,
  output logic [PRG_AW-1:0] prg_rom_addr,
  output logic [CHR_AW-1:0] chr_rom_addr,
  output logic              mirror_horiz
);
  logic [15:0]                            wr_sel;
  logic [PRG_BANK_W-1:0]                  prg_bank;
  logic [CHR_WINDOWS-1:0][CHR_BANK_W-1:0] chr_bank;

  cbm_reg_file u_regs (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .wr_sel(wr_sel), .prg_bank(prg_bank),
    .chr_bank(chr_bank), .mirror_horiz(mirror_horiz)
  );

  cbm_prg_xlate #(.PRG_BANKS(PRG_BANKS)) u_prg (
    .cpu_addr(cpu_addr), .prg_bank(prg_bank),
    .prg_rom_sel(prg_rom_sel), .prg_rom_addr(prg_rom_addr)
  );

  cbm_chr_xlate #(.CHR_BANKS(CHR_BANKS)) u_chr (
    .ppu_addr(ppu_addr), .chr_bank(chr_bank), .chr_rom_addr(chr_rom_addr)
  );
endmodule

// File: rtl/cbm_checker.sv
module cbm_checker
  import cbm_pkg::*;
#(
  parameter int unsigned PRG_BANKS = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [15:0]           cpu_addr,
  input logic [7:0]            cpu_data,
  input logic                  cpu_wr,
  input logic [15:0]           wr_sel,
  input logic [PRG_BANK_W-1:0] prg_bank,
  input logic                  mirror_horiz,
  input logic                  prg_rom_sel,
  input logic [PRG_AW-1:0]     prg_rom_addr
);
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel) && (!cpu_addr[15] -> wr_sel == '0)); // R1

  AST_LOW_UNSEL: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:13] == 3'b011) |-> !prg_rom_sel); // R6

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b11) |-> (32'(prg_rom_addr[PRG_AW-1:PRG_OFS_W]) == PRG_BANKS - 1)); // R4

  AST_MIRROR_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15] && cpu_addr[3:0] == 4'h9) |=> (mirror_horiz == $past(cpu_data[0]))); // R5

  AST_IGNORED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15] && cpu_addr[3:0] >= 4'hA) |=> ($stable(prg_bank) && $stable(mirror_horiz))); // R7

  AST_PRG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[15] |-> (32'(prg_rom_addr[PRG_AW-1:PRG_OFS_W]) < PRG_BANKS)); // R8
endmodule

bind cart_bank_mapper cbm_checker #(.PRG_BANKS(PRG_BANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
  .cpu_wr(cpu_wr), .wr_sel(wr_sel), .prg_bank(prg_bank),
  .mirror_horiz(mirror_horiz), .prg_rom_sel(prg_rom_sel),
  .prg_rom_addr(prg_rom_addr)
);

// File: tb/sim_cart_bank_mapper.sv
`timescale 1ns/1ps
module sim_cart_bank_mapper;
  localparam int unsigned NPRG = 8;
  localparam int unsigned NCHR = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_data = 8'h00;
  logic        cpu_wr = 1'b0;
  logic [12:0] ppu_addr = 13'h0000;
  logic        prg_rom_sel;
  logic [17:0] prg_rom_addr;
  logic [16:0] chr_rom_addr;
  logic        mirror_horiz;

  int checks = 0;
  int fails  = 0;
  int exp_chr [8];
  int exp_prg = 0;
  int exp_mir = 0;

  always #2.5 clk = ~clk;

  cart_bank_mapper #(.PRG_BANKS(NPRG), .CHR_BANKS(NCHR)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .prg_rom_sel(prg_rom_sel),
    .prg_rom_addr(prg_rom_addr), .chr_rom_addr(chr_rom_addr),
    .mirror_horiz(mirror_horiz)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic expect_prg(input string req, input logic [15:0] a, input int bank);
    cpu_addr = a; #1;
    check(req, int'(prg_rom_addr), bank * 16384 + int'(a[13:0]));
  endtask

  task automatic expect_chr(input string req, input int win, input int ofs);
    ppu_addr = 13'(win * 1024 + ofs); #1;
    check(req, int'(chr_rom_addr), exp_chr[win] * 1024 + ofs);
  endtask

  task automatic t_reset;
    for (int w = 0; w < 8; w++) exp_chr[w] = 0;
    expect_prg("R9", 16'h8123, 0);
    expect_prg("R4", 16'hC010, NPRG - 1);
    for (int w = 0; w < 8; w++) expect_chr("R9", w, 5);
    check("R9", int'(mirror_horiz), 0);
  endtask

  task automatic t_chr_windows;
    for (int w = 0; w < 8; w++) begin
      exp_chr[w] = 7 * w + 3;
      cpu_write(16'h8000 | 16'(w), 8'(exp_chr[w]));
    end
    for (int w = 0; w < 8; w++) begin
      expect_chr("R2", w, 0);
      expect_chr("R2", w, 1023);
    end
  endtask

  task automatic t_prg_window;
    cpu_write(16'h8008, 8'd5); exp_prg = 5;
    expect_prg("R3", 16'h8000, 5);
    expect_prg("R3", 16'hBFFF, 5);
    expect_prg("R4", 16'hFFFF, NPRG - 1);
    expect_prg("R4", 16'hC000, NPRG - 1);
  endtask

  task automatic t_mirror_decode;
    cpu_write(16'hF2A9, 8'h01); #1;
    check("R5", int'(mirror_horiz), 1);
    cpu_write(16'h8009, 8'hFE); #1;
    check("R5", int'(mirror_horiz), 0);
    cpu_write(16'hFFF8, 8'd2); exp_prg = 2;
    expect_prg("R1", 16'h9000, 2);
    cpu_write(16'h0008, 8'd6);
    expect_prg("R1", 16'h9000, 2);
    cpu_write(16'h7009, 8'h01); #1;
    check("R1", int'(mirror_horiz), 0);
  endtask

  task automatic t_ignored;
    for (int o = 10; o < 16; o++) cpu_write(16'h8000 | 16'(o), 8'hFF);
    expect_prg("R7", 16'h8400, exp_prg);
    check("R7", int'(mirror_horiz), 0);
    for (int w = 0; w < 8; w++) expect_chr("R7", w, 17);
  endtask

  task automatic t_select;
    cpu_addr = 16'h6000; #1; check("R6", int'(prg_rom_sel), 0);
    cpu_addr = 16'h7FFF; #1; check("R6", int'(prg_rom_sel), 0);
    cpu_addr = 16'h8000; #1; check("R6", int'(prg_rom_sel), 1);
    cpu_addr = 16'hFFFF; #1; check("R6", int'(prg_rom_sel), 1);
  endtask

  task automatic t_wrap;
    cpu_write(16'h8008, 8'd13); exp_prg = 13 % NPRG;
    expect_prg("R8", 16'h8001, exp_prg);
    expect_prg("R8", 16'hC001, NPRG - 1);
    cpu_write(16'h8003, 8'd100); exp_chr[3] = 100 % NCHR;
    expect_chr("R8", 3, 200);
    cpu_write(16'h8004, 8'hC5); exp_chr[4] = (8'hC5 & 8'h7F) % NCHR;
    expect_chr("R8", 4, 9);
  endtask

  task automatic t_edge_timing;
    @(negedge clk);
    cpu_addr = 16'h8008; cpu_data = 8'd3; cpu_wr = 1'b1; #1;
    check("R10", int'(prg_rom_addr), exp_prg * 16384 + 8);
    @(posedge clk); #1;
    check("R10", int'(prg_rom_addr), 3 * 16384 + 8);
    @(negedge clk); cpu_wr = 1'b0; exp_prg = 3;
  endtask

  initial begin
    fork
      begin
        #50000;
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_chr_windows;
    t_prg_window;
    t_mirror_decode;
    t_ignored;
    t_select;
    t_wrap;
    t_edge_timing;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule